// File: doc/BRIEF.md
# Scoreboard Hazard Scheduler

This block schedules instructions for five functional units. It dispatches in order, lets instructions issue out of order, and does no register renaming. One functional-unit entry exists for each unit: an integer ALU, a load unit, a store unit and two floating-point units. Each entry records the instruction's destination, its two sources, and the tag of the unit that will produce each source. A register status table holds, for each architectural register, the tag of the unit that will write it next.

Each cycle the front end may present one decoded instruction: an operation class, a destination with an enable, and two source registers. The scheduler accepts the instruction into a free unit of that class, or it reports a structural or write-after-write stall. Each unit entry is a small state machine with four states:
- `US_FREE`
- `US_WAIT` (dispatched, waiting for operands)
- `US_EXEC` (issued, executing)
- `US_DONE` (finished, waiting for writeback)

The transitions are:
- alloc: `US_FREE` to `US_WAIT`
- issue: `US_WAIT` to `US_EXEC`
- done pulse: `US_EXEC` to `US_DONE`
- writeback grant: `US_DONE` to `US_FREE`, or `US_DONE` to `US_WAIT` when the unit is reallocated in the same cycle

The execution units report completion with a one-cycle done pulse per unit. The scheduler grants writeback to one unit per cycle. It holds a writeback back while an older, not-yet-issued instruction still needs the register's old value.

Top module: `scoreboard_sched`

## Requirements
- R1: After a synchronous active-high reset, all units are free. `busy_vec`, `issue_vec` and `wb_vec` are zero, and every register status entry is empty.
- R2: The class encoding is 0 = ALU, 1 = load, 2 = store, 3 = floating point. Tags are 0 for none, then 1 = ALU, 2 = load, 3 = store, 4 = first FP unit, 5 = second FP unit. Bit tag-1 of every unit vector belongs to that unit. An accepted instruction raises `disp_fire` and reports its unit's tag on `disp_tag`. When both FP units are free, the first FP unit (tag 4) is taken.
- R3: If no unit of the requested class is free, `stall_struct` is 1 and nothing is dispatched.
- R4: If `in_dst_en` is 1 and the destination register already has a pending writer, `stall_waw` is 1 and nothing is dispatched. An instruction with `in_dst_en` = 0 never raises this stall.
- R5: At dispatch, each source's producer tag is copied from the register status table. A unit issues (its `issue_vec` bit is 1 for one cycle) no earlier than the cycle after dispatch, and only when both of its source tags are empty.
- R6: A unit that is executing moves to writeback request on its `exec_done` pulse. Without contention it writes back in the following cycle, and it stays busy until then.
- R7: A finished unit with a destination does not write back while another unit is waiting for operands, is not issuing on already-ready tags, and holds a source equal to that destination with an empty tag. Its `war_wait` bit is 1 meanwhile.
- R8: A writeback clears every source tag equal to the writer's tag. A unit whose last pending tag is cleared issues in that same cycle.
- R9: A writeback frees the unit and clears the destination's register status entry if it still holds that tag. In the same cycle, a dispatch may take the freed unit, and a destination whose only pending writer is writing back is not a write-after-write stall.
- R10: At most one unit writes back per cycle. Among units that are allowed to write back, the lowest tag wins.
- R11: A source dispatched in the same cycle as the writeback of its producer is captured as ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decoded instruction present |
| in_class | input | 2 | Operation class (0 ALU, 1 load, 2 store, 3 FP) |
| in_dst | input | REG_W | Destination register |
| in_dst_en | input | 1 | Instruction writes a destination |
| in_src1 | input | REG_W | First source register |
| in_src2 | input | REG_W | Second source register |
| exec_done | input | 5 | Per-unit execution complete pulse |
| disp_fire | output | 1 | Instruction accepted this cycle |
| disp_tag | output | 3 | Tag of the allocated unit, 0 if none |
| stall_struct | output | 1 | No free unit of the class |
| stall_waw | output | 1 | Destination has a pending writer |
| issue_vec | output | 5 | Units reading operands this cycle |
| wb_vec | output | 5 | Unit granted writeback this cycle |
| war_wait | output | 5 | Finished units held by a WAR hazard |
| busy_vec | output | 5 | Units not free |

## Verification
The bench targets the same-cycle interactions, because a scheduler that orders them wrongly deadlocks or corrupts state. The cases it drives are:
- Dispatch into a unit that is writing back: a design that allocated before freeing would report a structural stall.
- A dependent issue in the cycle of its producer's writeback: a design that missed the broadcast would add a cycle.
- A source captured while its producer writes back: a design that copied the stale tag would wait forever.
- A writeback held by an older reader that is still waiting: a design that ignored the hold would let the reader see the new value.
- Priority between two finished FP units, and the first-FP-unit preference.
- A store with no destination, which must not cause a write-after-write stall.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int NUM_UNITS = 5;
    localparam int TAG_W     = $clog2(NUM_UNITS + 1);

    localparam int U_ALU = 0;
    localparam int U_LD  = 1;
    localparam int U_ST  = 2;
    localparam int U_FPA = 3;
    localparam int U_FPB = 4;

    typedef enum logic [1:0] {
        CLS_ALU = 2'd0,
        CLS_LD  = 2'd1,
        CLS_ST  = 2'd2,
        CLS_FP  = 2'd3
    } op_class_e;

    typedef enum logic [1:0] {
        US_FREE = 2'd0,
        US_WAIT = 2'd1,
        US_EXEC = 2'd2,
        US_DONE = 2'd3
    } unit_state_e;
endpackage

// File: rtl/sb_unit_entry.sv
module sb_unit_entry import sb_pkg::*; #(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc,
    input  logic [REG_W-1:0] a_dst,
    input  logic             a_dst_en,
    input  logic [REG_W-1:0] a_src1,
    input  logic [REG_W-1:0] a_src2,
    input  logic [TAG_W-1:0] a_tag1,
    input  logic [TAG_W-1:0] a_tag2,
    input  logic [TAG_W-1:0] bc_tag,
    input  logic             wb_gnt,
    input  logic             exec_done,
    output logic             busy,
    output logic             waiting,
    output logic             ops_ready,
    output logic             issue,
    output logic             wb_req,
    output logic [REG_W-1:0] dst,
    output logic             dst_en,
    output logic [REG_W-1:0] src1,
    output logic [REG_W-1:0] src2,
    output logic [TAG_W-1:0] tag1,
    output logic [TAG_W-1:0] tag2
);
    unit_state_e st_q, st_d;
    logic t1_hit, t2_hit;

    assign t1_hit = (bc_tag != '0) && (tag1 == bc_tag);
    assign t2_hit = (bc_tag != '0) && (tag2 == bc_tag);

    always_ff @(posedge clk) begin
        if (rst) st_q <= US_FREE;
        else     st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            US_FREE: if (alloc)     st_d = US_WAIT;
            US_WAIT: if (issue)     st_d = US_EXEC;
            US_EXEC: if (exec_done) st_d = US_DONE;
            US_DONE: if (wb_gnt)    st_d = alloc ? US_WAIT : US_FREE;
            default:                st_d = US_FREE;
        endcase
    end

    always_comb begin
        busy      = (st_q != US_FREE);
        waiting   = (st_q == US_WAIT);
        ops_ready = (st_q == US_WAIT) && (tag1 == '0) && (tag2 == '0);
        issue     = (st_q == US_WAIT) && ((tag1 == '0) || t1_hit)
                                      && ((tag2 == '0) || t2_hit);
        wb_req    = (st_q == US_DONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dst    <= '0;
            dst_en <= 1'b0;
            src1   <= '0;
            src2   <= '0;
            tag1   <= '0;
            tag2   <= '0;
        end else if (alloc) begin
            dst    <= a_dst;
            dst_en <= a_dst_en;
            src1   <= a_src1;
            src2   <= a_src2;
            tag1   <= a_tag1;
            tag2   <= a_tag2;
        end else begin
            if (t1_hit) tag1 <= '0;
            if (t2_hit) tag2 <= '0;
        end
    end
endmodule

// File: rtl/sb_reg_status.sv
module sb_reg_status import sb_pkg::*; #(
    parameter int NUM_REGS = 32,
    parameter int REG_W    = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] rd_dst,
    input  logic [REG_W-1:0] rd_s1,
    input  logic [REG_W-1:0] rd_s2,
    output logic [TAG_W-1:0] tag_dst,
    output logic [TAG_W-1:0] tag_s1,
    output logic [TAG_W-1:0] tag_s2,
    input  logic             clr_en,
    input  logic [REG_W-1:0] clr_reg,
    input  logic [TAG_W-1:0] clr_tag,
    input  logic             set_en,
    input  logic [REG_W-1:0] set_reg,
    input  logic [TAG_W-1:0] set_tag
);
    logic [TAG_W-1:0] tbl [NUM_REGS];

    assign tag_dst = tbl[rd_dst];
    assign tag_s1  = tbl[rd_s1];
    assign tag_s2  = tbl[rd_s2];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) tbl[i] <= '0;
        end else begin
            if (clr_en && (tbl[clr_reg] == clr_tag)) tbl[clr_reg] <= '0;
            if (set_en) tbl[set_reg] <= set_tag;
        end
    end
endmodule

// File: rtl/sb_wb_arbiter.sv
module sb_wb_arbiter import sb_pkg::*; #(
    parameter int REG_W = 5
) (
    input  logic [NUM_UNITS-1:0]            req,
    input  logic [NUM_UNITS-1:0]            dst_en,
    input  logic [NUM_UNITS-1:0][REG_W-1:0] dst,
    input  logic [NUM_UNITS-1:0]            rd_wait,
    input  logic [NUM_UNITS-1:0][REG_W-1:0] src1,
    input  logic [NUM_UNITS-1:0][REG_W-1:0] src2,
    input  logic [NUM_UNITS-1:0]            tag1_z,
    input  logic [NUM_UNITS-1:0]            tag2_z,
    output logic [NUM_UNITS-1:0]            war_hold,
    output logic [NUM_UNITS-1:0]            gnt
);
    logic [NUM_UNITS-1:0] elig;

    for (genvar w = 0; w < NUM_UNITS; w++) begin : g_war
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int r = 0; r < NUM_UNITS; r++) begin
                if (r != w && rd_wait[r] &&
                    ((src1[r] == dst[w] && tag1_z[r]) ||
                     (src2[r] == dst[w] && tag2_z[r])))
                    hit = 1'b1;
            end
        end
        assign war_hold[w] = req[w] && dst_en[w] && hit;
    end

    assign elig = req & ~war_hold;

    always_comb begin
        gnt = '0;
        for (int i = NUM_UNITS - 1; i >= 0; i--) begin
            if (elig[i]) gnt = NUM_UNITS'(1) << i;
        end
    end
endmodule

// File: rtl/scoreboard_sched.sv
module scoreboard_sched import sb_pkg::*; #(
    parameter int NUM_REGS = 32,
    localparam int REG_W   = $clog2(NUM_REGS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [1:0]           in_class,
    input  logic [REG_W-1:0]     in_dst,
    input  logic                 in_dst_en,
    input  logic [REG_W-1:0]     in_src1,
    input  logic [REG_W-1:0]     in_src2,
    input  logic [NUM_UNITS-1:0] exec_done,
    output logic                 disp_fire,
    output logic [TAG_W-1:0]     disp_tag,
    output logic                 stall_struct,
    output logic                 stall_waw,
    output logic [NUM_UNITS-1:0] issue_vec,
    output logic [NUM_UNITS-1:0] wb_vec,
    output logic [NUM_UNITS-1:0] war_wait,
    output logic [NUM_UNITS-1:0] busy_vec
);
    logic [NUM_UNITS-1:0] u_busy, u_wait, u_ready, u_issue, u_req, u_dst_en;
    logic [NUM_UNITS-1:0] alloc_vec, gnt, avail, tag1_z, tag2_z;
    logic [NUM_UNITS-1:0][REG_W-1:0] u_dst, u_src1, u_src2;
    logic [NUM_UNITS-1:0][TAG_W-1:0] u_tag1, u_tag2;

    logic [TAG_W-1:0] bc_tag, rs_dst_tag, rs_s1_tag, rs_s2_tag;
    logic [TAG_W-1:0] cap_tag1, cap_tag2, pick_tag;
    logic [REG_W-1:0] wb_dst;
    logic             wb_dst_en, pick_ok, waw_hit;

    // writeback broadcast tag and destination of the granted unit
    always_comb begin
        bc_tag    = '0;
        wb_dst    = '0;
        wb_dst_en = 1'b0;
        for (int i = 0; i < NUM_UNITS; i++) begin
            if (gnt[i]) begin
                bc_tag    = TAG_W'(i + 1);
                wb_dst    = u_dst[i];
                wb_dst_en = u_dst_en[i];
            end
        end
    end

    // a unit granted writeback this cycle is free for a new dispatch
    assign avail = ~u_busy | gnt;

    always_comb begin
        pick_ok  = 1'b0;
        pick_tag = '0;
        case (op_class_e'(in_class))
            CLS_ALU: if (avail[U_ALU]) begin pick_ok = 1'b1; pick_tag = TAG_W'(U_ALU + 1); end
            CLS_LD:  if (avail[U_LD])  begin pick_ok = 1'b1; pick_tag = TAG_W'(U_LD + 1);  end
            CLS_ST:  if (avail[U_ST])  begin pick_ok = 1'b1; pick_tag = TAG_W'(U_ST + 1);  end
            CLS_FP: begin
                if (avail[U_FPA])      begin pick_ok = 1'b1; pick_tag = TAG_W'(U_FPA + 1); end
                else if (avail[U_FPB]) begin pick_ok = 1'b1; pick_tag = TAG_W'(U_FPB + 1); end
            end
            default: pick_ok = 1'b0;
        endcase
    end

    assign waw_hit      = in_dst_en && (rs_dst_tag != '0) && (rs_dst_tag != bc_tag);
    assign disp_fire    = in_valid && pick_ok && !waw_hit;
    assign disp_tag     = disp_fire ? pick_tag : '0;
    assign stall_struct = in_valid && !pick_ok;
    assign stall_waw    = in_valid && waw_hit;

    // a producer writing back this cycle counts as already done
    assign cap_tag1 = (rs_s1_tag == bc_tag) ? '0 : rs_s1_tag;
    assign cap_tag2 = (rs_s2_tag == bc_tag) ? '0 : rs_s2_tag;

    sb_reg_status #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_rstat (
        .clk     (clk),
        .rst     (rst),
        .rd_dst  (in_dst),
        .rd_s1   (in_src1),
        .rd_s2   (in_src2),
        .tag_dst (rs_dst_tag),
        .tag_s1  (rs_s1_tag),
        .tag_s2  (rs_s2_tag),
        .clr_en  (wb_dst_en),
        .clr_reg (wb_dst),
        .clr_tag (bc_tag),
        .set_en  (disp_fire && in_dst_en),
        .set_reg (in_dst),
        .set_tag (pick_tag)
    );

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        assign alloc_vec[u] = disp_fire && (pick_tag == TAG_W'(u + 1));
        assign tag1_z[u]    = (u_tag1[u] == '0);
        assign tag2_z[u]    = (u_tag2[u] == '0);

        sb_unit_entry #(.REG_W(REG_W)) u_ent (
            .clk       (clk),
            .rst       (rst),
            .alloc     (alloc_vec[u]),
            .a_dst     (in_dst),
            .a_dst_en  (in_dst_en),
            .a_src1    (in_src1),
            .a_src2    (in_src2),
            .a_tag1    (cap_tag1),
            .a_tag2    (cap_tag2),
            .bc_tag    (bc_tag),
            .wb_gnt    (gnt[u]),
            .exec_done (exec_done[u]),
            .busy      (u_busy[u]),
            .waiting   (u_wait[u]),
            .ops_ready (u_ready[u]),
            .issue     (u_issue[u]),
            .wb_req    (u_req[u]),
            .dst       (u_dst[u]),
            .dst_en    (u_dst_en[u]),
            .src1      (u_src1[u]),
            .src2      (u_src2[u]),
            .tag1      (u_tag1[u]),
            .tag2      (u_tag2[u])
        );
    end

    sb_wb_arbiter #(.REG_W(REG_W)) u_arb (
        .req      (u_req),
        .dst_en   (u_dst_en),
        .dst      (u_dst),
        .rd_wait  (u_wait & ~u_ready),
        .src1     (u_src1),
        .src2     (u_src2),
        .tag1_z   (tag1_z),
        .tag2_z   (tag2_z),
        .war_hold (war_wait),
        .gnt      (gnt)
    );

    assign issue_vec = u_issue;
    assign wb_vec    = gnt;
    assign busy_vec  = u_busy;
endmodule

// File: rtl/scoreboard_sched_chk.sv
module scoreboard_sched_chk import sb_pkg::*; (
    input logic                 clk,
    input logic                 rst,
    input logic                 disp_fire,
    input logic [TAG_W-1:0]     disp_tag,
    input logic                 stall_struct,
    input logic                 stall_waw,
    input logic [NUM_UNITS-1:0] issue_vec,
    input logic [NUM_UNITS-1:0] wb_vec,
    input logic [NUM_UNITS-1:0] war_wait,
    input logic [NUM_UNITS-1:0] busy_vec
);
    logic [NUM_UNITS-1:0] disp_mask;
    always_comb disp_mask = (disp_tag != '0) ? (NUM_UNITS'(1) << (disp_tag - 1'b1)) : '0;

    // R10
    wb_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(wb_vec));
    // R3
    struct_no_fire_chk: assert property (@(posedge clk) disable iff (rst) stall_struct |-> !disp_fire);
    // R4
    waw_no_fire_chk: assert property (@(posedge clk) disable iff (rst) stall_waw |-> !disp_fire);
    // R2
    disp_busy_chk: assert property (@(posedge clk) disable iff (rst)
        disp_fire |=> ((busy_vec & $past(disp_mask)) != '0));
    // R9
    wb_frees_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_vec != '0 && !disp_fire) |=> ((busy_vec & $past(wb_vec)) == '0));
    // R6
    issued_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_vec != '0) |=> ((busy_vec & $past(issue_vec)) == $past(issue_vec)));
    // R7
    war_no_wb_chk: assert property (@(posedge clk) disable iff (rst) (war_wait & wb_vec) == '0);
endmodule

bind scoreboard_sched scoreboard_sched_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .disp_fire    (disp_fire),
    .disp_tag     (disp_tag),
    .stall_struct (stall_struct),
    .stall_waw    (stall_waw),
    .issue_vec    (issue_vec),
    .wb_vec       (wb_vec),
    .war_wait     (war_wait),
    .busy_vec     (busy_vec)
);

// File: tb/tb_scoreboard_sched.sv
module tb_scoreboard_sched;
    localparam int CLK_P    = 10;
    localparam int NREGS    = 32;
    localparam int RW       = $clog2(NREGS);
    localparam logic [1:0] C_ALU = 2'd0, C_LD = 2'd1, C_ST = 2'd2, C_FP = 2'd3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [1:0]    in_class = '0;
    logic [RW-1:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
    logic          in_dst_en = 1'b0;
    logic [4:0]    exec_done = '0;
    logic          disp_fire, stall_struct, stall_waw;
    logic [2:0]    disp_tag;
    logic [4:0]    issue_vec, wb_vec, war_wait, busy_vec;

    int checks = 0;
    int failures = 0;

    always #(CLK_P/2) clk = ~clk;

    scoreboard_sched #(.NUM_REGS(NREGS)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_class(in_class),
        .in_dst(in_dst), .in_dst_en(in_dst_en), .in_src1(in_src1), .in_src2(in_src2),
        .exec_done(exec_done), .disp_fire(disp_fire), .disp_tag(disp_tag),
        .stall_struct(stall_struct), .stall_waw(stall_waw), .issue_vec(issue_vec),
        .wb_vec(wb_vec), .war_wait(war_wait), .busy_vec(busy_vec)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [1:0] c, input int d, input logic de,
                         input int s1, input int s2, input logic [4:0] dn);
        @(negedge clk);
        in_valid  = v;
        in_class  = c;
        in_dst    = RW'(d);
        in_dst_en = de;
        in_src1   = RW'(s1);
        in_src2   = RW'(s2);
        exec_done = dn;
        #1;
    endtask

    task automatic idle();
        drive(1'b0, C_ALU, 0, 1'b0, 0, 0, 5'b0);
    endtask

    task automatic drain();
        for (int i = 0; i < 14; i++) drive(1'b0, C_ALU, 0, 1'b0, 0, 0, 5'b11111);
        idle();
        check("R9", "busy after drain", int'(busy_vec), 0);
    endtask

    task automatic t_reset();
        check("R1", "busy after reset", int'(busy_vec), 0);
        check("R1", "issue after reset", int'(issue_vec), 0);
        check("R1", "wb after reset", int'(wb_vec), 0);
    endtask

    task automatic t_basic();
        drive(1'b1, C_ALU, 1, 1'b1, 2, 3, 5'b0);
        check("R2", "alu fire", int'(disp_fire), 1);
        check("R2", "alu tag", int'(disp_tag), 1);
        check("R1", "no waw on empty table", int'(stall_waw), 0);
        idle();
        check("R5", "alu issue", int'(issue_vec), 5'b00001);
        drive(1'b0, C_ALU, 0, 1'b0, 0, 0, 5'b00001);
        check("R6", "no wb during done pulse", int'(wb_vec), 0);
        check("R6", "still busy", int'(busy_vec), 5'b00001);
        idle();
        check("R6", "wb after done", int'(wb_vec), 5'b00001);
        idle();
        check("R9", "freed", int'(busy_vec), 0);
    endtask

    task automatic t_fp_struct();
        drive(1'b1, C_FP, 4, 1'b1, 5, 6, 5'b0);
        check("R2", "first fp tag", int'(disp_tag), 4);
        drive(1'b1, C_FP, 7, 1'b1, 5, 6, 5'b0);
        check("R2", "second fp tag", int'(disp_tag), 5);
        drive(1'b1, C_FP, 8, 1'b1, 5, 6, 5'b0);
        check("R3", "struct stall", int'(stall_struct), 1);
        check("R3", "no fire when full", int'(disp_fire), 0);
        check("R3", "no waw flag", int'(stall_waw), 0);
        drive(1'b0, C_ALU, 0, 1'b0, 0, 0, 5'b11000);
        drive(1'b1, C_FP, 8, 1'b1, 5, 6, 5'b0);
        check("R10", "lowest tag wins", int'(wb_vec), 5'b01000);
        check("R9", "dispatch into freed unit", int'(disp_fire), 1);
        check("R9", "freed unit tag", int'(disp_tag), 4);
        idle();
        check("R10", "second fp wb next", int'(wb_vec), 5'b10000);
        check("R5", "new fp issue", int'(issue_vec), 5'b01000);
        drive(1'b0, C_ALU, 0, 1'b0, 0, 0, 5'b01000);
        idle();
        check("R6", "reused fp wb", int'(wb_vec), 5'b01000);
        idle();
        check("R9", "all free", int'(busy_vec), 0);
    endtask

    task automatic t_waw();
        drive(1'b1, C_LD, 9, 1'b1, 1, 2, 5'b0);
        check("R2", "load tag", int'(disp_tag), 2);
        drive(1'b1, C_ALU, 9, 1'b1, 1, 2, 5'b0);
        check("R4", "waw stall", int'(stall_waw), 1);
        check("R4", "no fire on waw", int'(disp_fire), 0);
        drive(1'b0, C_ALU, 0, 1'b0, 0, 0, 5'b00010);
        drive(1'b1, C_ALU, 9, 1'b1, 1, 2, 5'b0);
        check("R9", "load wb", int'(wb_vec), 5'b00010);
        check("R9", "waw cleared same cycle", int'(stall_waw), 0);
        check("R9", "fire same cycle", int'(disp_fire), 1);
        drive(1'b1, C_ST, 9, 1'b0, 1, 2, 5'b0);
        check("R4", "store no dst no waw", int'(stall_waw), 0);
        check("R2", "store tag", int'(disp_tag), 3);
        drain();
    endtask

    task automatic t_raw();
        drive(1'b1, C_FP, 10, 1'b1, 1, 2, 5'b0);
        drive(1'b1, C_ALU, 11, 1'b1, 10, 3, 5'b0);
        check("R5", "fp issues", int'(issue_vec), 5'b01000);
        drive(1'b0, C_ALU, 0, 1'b0, 0, 0, 5'b01000);
        check("R5", "dependent waits", int'(issue_vec), 0);
        idle();
        check("R8", "producer wb", int'(wb_vec), 5'b01000);
        check("R8", "dependent issues same cycle", int'(issue_vec), 5'b00001);
        drain();
    endtask

    task automatic t_war();
        drive(1'b1, C_FP, 12, 1'b1, 1, 2, 5'b0);
        drive(1'b1, C_ST, 0, 1'b0, 12, 13, 5'b0);
        drive(1'b1, C_ALU, 13, 1'b1, 1, 2, 5'b0);
        idle();
        check("R5", "alu issues past stalled store", int'(issue_vec), 5'b00001);
        drive(1'b0, C_ALU, 0, 1'b0, 0, 0, 5'b00001);
        idle();
        check("R7", "wb held", int'(wb_vec), 0);
        check("R7", "war flag", int'(war_wait), 5'b00001);
        drive(1'b0, C_ALU, 0, 1'b0, 0, 0, 5'b01000);
        idle();
        check("R7", "fp wb while alu held", int'(wb_vec), 5'b01000);
        check("R8", "store issues on broadcast", int'(issue_vec), 5'b00100);
        idle();
        check("R7", "alu wb released", int'(wb_vec), 5'b00001);
        check("R7", "war flag cleared", int'(war_wait), 0);
        drain();
    endtask

    task automatic t_capture();
        drive(1'b1, C_LD, 14, 1'b1, 1, 2, 5'b0);
        idle();
        drive(1'b0, C_ALU, 0, 1'b0, 0, 0, 5'b00010);
        drive(1'b1, C_ALU, 15, 1'b1, 14, 14, 5'b0);
        check("R11", "load wb", int'(wb_vec), 5'b00010);
        check("R11", "fire", int'(disp_fire), 1);
        idle();
        check("R11", "captured ready, issues", int'(issue_vec), 5'b00001);
        drain();
    endtask

    initial begin
        for (int i = 0; i < 3; i++) idle();
        @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_basic();
        t_fp_struct();
        t_waw();
        t_raw();
        t_war();
        t_capture();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule